// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial characters on a single idle-high line. It is clocked at sixteen times the bit rate. A falling edge on the line begins a frame. The start bit is checked again at its centre, so that a short low pulse is thrown away as noise. Every later bit is sampled once, at its centre.

The block takes five to eight data bits, least significant first, then an optional parity bit, then one stop bit. It moves the finished word into an eight-bit holding register and sets a ready flag. Three error flags are updated in the same cycle: parity, framing and overrun.

The surrounding logic reads the word and then pulses an active-low clear to drop the ready flag. The word length, parity enable and parity sense are static control inputs. An active-low master reset clears every flag.

Top module: `serial_rx_flags`

## Requirements
- R1: While the master reset `rst_n` is low, and after it is released, `rx_ready`, `err_parity`, `err_frame`, `err_overrun` and `rx_word` are all zero until a frame is accepted.
- R2: A frame begins only on a high-to-low transition of `rxd`. If the line reads high again at the centre of the start bit (sample 8 of 16), the frame is dropped and `rx_ready` stays unchanged.
- R3: `len_sel` selects the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. The first bit received lands in `rx_word[0]`, and the bits of `rx_word` above the selected length read zero.
- R4: A bit lasts 16 clocks and is sampled only at its centre. A line that holds the wrong value for the first 3 and the last 3 clocks of each data bit still yields the correct word.
- R5: Each accepted frame loads `rx_word` and sets `rx_ready`. A low level on `drf_clr_n` clears `rx_ready` and leaves `rx_word` unchanged.
- R6: `err_frame` is set when the stop-bit sample reads low, and cleared when it reads high.
- R7: When parity is enabled, `par_even`=1 selects even parity (data bits plus parity bit hold an even number of ones) and `par_even`=0 selects odd parity. `err_parity` is set when the received parity bit does not match.
- R8: While `par_off` is high, no parity bit is expected (the stop bit follows the last data bit) and `err_parity` reads low.
- R9: `err_overrun` is set when a word is loaded while `rx_ready` is still high, and cleared when a word is loaded while `rx_ready` is low.
- R10: All error flags are rewritten together with each word load and describe only the most recent word. Between loads they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 16 times the bit rate |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| rxd | input | 1 | Serial input line, idle high |
| len_sel | input | 2 | Data length select (5 to 8 bits) |
| par_off | input | 1 | High: no parity bit, parity error held low |
| par_even | input | 1 | Parity sense: 1 even, 0 odd |
| drf_clr_n | input | 1 | Active-low clear of the ready flag |
| rx_word | output | 8 | Last received word, zero-extended |
| rx_ready | output | 1 | A word has been loaded since the last clear |
| err_parity | output | 1 | Parity mismatch on the last word |
| err_frame | output | 1 | Stop bit read low on the last word |
| err_overrun | output | 1 | Last word overwrote an unread word |

## Verification
The bench builds the block with its default parameters: 16 samples per bit, an eight-bit maximum word, and two synchronizer stages. At this size every data value can be sent at every one of the four lengths. The sweep rotates through no parity, even parity and odd parity, so each value of the upper-bit masking and of the parity sense is covered.

Directed frames then add the remaining cases:
- noise pulses shorter than half a bit;
- data bits corrupted at their edges;
- corrupted parity and stop bits;
- back-to-back words with no clear, to test overrun;
- a master reset while the flags are set.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int MAX_BITS   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line,
  input  logic [1:0]          len_sel,
  input  logic                par_off,
  output logic                done,
  output logic [MAX_BITS-1:0] word,
  output logic                par_bit,
  output logic                stop_ok
);
  localparam int CNT_W    = $clog2(OVERSAMPLE);
  localparam int IDX_W    = $clog2(MAX_BITS);
  localparam int MID      = OVERSAMPLE / 2;
  localparam int MIN_BITS = MAX_BITS - 3;

  rx_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [MAX_BITS-1:0] shift_q, shift_d;
  logic                par_q, par_d;
  logic                prev_q;
  logic                done_q, done_d;
  logic                stop_q, stop_d;
  logic                at_mid, at_end;
  logic [IDX_W-1:0]    last_idx;

  assign at_mid   = (cnt_q == CNT_W'(MID));
  assign at_end   = (cnt_q == CNT_W'(OVERSAMPLE - 1));
  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(len_sel);

  always_comb begin
    state_d = state_q;
    cnt_d   = at_end ? '0 : cnt_q + 1'b1;
    idx_d   = idx_q;
    shift_d = shift_q;
    par_d   = par_q;
    done_d  = 1'b0;
    stop_d  = stop_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (prev_q && !line) begin
          state_d = ST_START;
          cnt_d   = CNT_W'(1);
          idx_d   = '0;
          shift_d = '0;
        end
      end
      ST_START: begin
        if (at_mid && line) state_d = ST_IDLE;
        else if (at_end)    state_d = ST_DATA;
      end
      ST_DATA: begin
        if (at_mid) shift_d[idx_q] = line;
        if (at_end) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == last_idx) state_d = par_off ? ST_STOP : ST_PAR;
        end
      end
      ST_PAR: begin
        if (at_mid) par_d = line;
        if (at_end) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (at_mid) begin
          done_d  = 1'b1;
          stop_d  = line;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      prev_q  <= 1'b1;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      par_q   <= par_d;
      prev_q  <= line;
      done_q  <= done_d;
      stop_q  <= stop_d;
    end
  end

  assign done    = done_q;
  assign word    = shift_q;
  assign par_bit = par_q;
  assign stop_ok = stop_q;
endmodule

// File: rtl/rx_result_reg.sv
module rx_result_reg #(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] word_in,
  input  logic                par_bit,
  input  logic                stop_ok,
  input  logic                par_off,
  input  logic                par_even,
  input  logic                clr_n,
  output logic [MAX_BITS-1:0] word_out,
  output logic                ready,
  output logic                perr,
  output logic                ferr,
  output logic                oerr
);
  logic [MAX_BITS-1:0] word_q, word_d;
  logic ready_q, ready_d;
  logic pe_q, pe_d;
  logic fe_q, fe_d;
  logic oe_q, oe_d;

  always_comb begin
    word_d  = word_q;
    ready_d = ready_q;
    pe_d    = pe_q;
    fe_d    = fe_q;
    oe_d    = oe_q;
    if (!clr_n) ready_d = 1'b0;
    if (load) begin
      word_d  = word_in;
      ready_d = 1'b1;
      pe_d    = ~par_off & (^word_in ^ par_bit ^ ~par_even);
      fe_d    = ~stop_ok;
      oe_d    = ready_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ready_q <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      word_q  <= word_d;
      ready_q <= ready_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      oe_q    <= oe_d;
    end
  end

  assign word_out = word_q;
  assign ready    = ready_q;
  assign perr     = pe_q & ~par_off;
  assign ferr     = fe_q;
  assign oerr     = oe_q;
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int OVERSAMPLE  = 16,
  parameter int MAX_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxd,
  input  logic [1:0]          len_sel,
  input  logic                par_off,
  input  logic                par_even,
  input  logic                drf_clr_n,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_ready,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun
);
  logic                rst_n_s;
  logic                line_s;
  logic                done_w;
  logic [MAX_BITS-1:0] word_w;
  logic                par_w;
  logic                stop_w;

  rx_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_n_s)
  );

  rx_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n_s), .din(rxd), .dout(line_s)
  );

  rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE), .MAX_BITS(MAX_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .line(line_s), .len_sel(len_sel),
    .par_off(par_off), .done(done_w), .word(word_w),
    .par_bit(par_w), .stop_ok(stop_w)
  );

  rx_result_reg #(.MAX_BITS(MAX_BITS)) u_result (
    .clk(clk), .rst_n(rst_n_s), .load(done_w), .word_in(word_w),
    .par_bit(par_w), .stop_ok(stop_w), .par_off(par_off),
    .par_even(par_even), .clr_n(drf_clr_n), .word_out(rx_word),
    .ready(rx_ready), .perr(err_parity), .ferr(err_frame),
    .oerr(err_overrun)
  );
endmodule

// File: rtl/serial_rx_flags_chk.sv
module serial_rx_flags_chk #(
  parameter int MAX_BITS = 8
) (
  input logic                clk,
  input logic                rst_n_s,
  input logic                done_w,
  input logic                stop_w,
  input logic                drf_clr_n,
  input logic                par_off,
  input logic [1:0]          len_sel,
  input logic [MAX_BITS-1:0] rx_word,
  input logic                rx_ready,
  input logic                err_parity,
  input logic                err_frame,
  input logic                err_overrun
);
  assert_load_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_w |=> rx_ready);

  assert_clear_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!drf_clr_n && !done_w) |=> !rx_ready);

  assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done_w |=> $stable(rx_word));

  assert_overrun_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_w && rx_ready) |=> err_overrun);

  assert_overrun_clean_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_w && !rx_ready) |=> !err_overrun);

  assert_frame_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_w |=> (err_frame == !$past(stop_w)));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !done_w |=> ($stable(err_frame) && $stable(err_overrun)));

  assert_short_word_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_w && len_sel == 2'b00) |=> (rx_word[MAX_BITS-1:MAX_BITS-3] == 3'b000));

  assert_parity_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (par_off && $stable(par_off)) |-> !err_parity);
endmodule

bind serial_rx_flags serial_rx_flags_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .done_w(done_w), .stop_w(stop_w),
  .drf_clr_n(drf_clr_n), .par_off(par_off), .len_sel(len_sel),
  .rx_word(rx_word), .rx_ready(rx_ready), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun)
);

// File: tb/tb_serial_rx_flags.sv
module tb_serial_rx_flags;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd;
  logic [1:0] len_sel;
  logic       par_off;
  logic       par_even;
  logic       drf_clr_n;
  logic [7:0] rx_word;
  logic       rx_ready, err_parity, err_frame, err_overrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_rx_flags dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .len_sel(len_sel),
    .par_off(par_off), .par_even(par_even), .drf_clr_n(drf_clr_n),
    .rx_word(rx_word), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    for (int k = 0; k < 16; k++) begin
      rxd = (glitch && (k < 3 || k > 12)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  // pmode: 0 no parity, 1 even, 2 odd
  task automatic send(input logic [7:0] d, input int nb, input int pmode,
                      input bit badpar, input bit badstop, input bit glitch);
    logic p;
    logic [7:0] m;
    m        = d & 8'((1 << nb) - 1);
    len_sel  = 2'(nb - 5);
    par_off  = (pmode == 0);
    par_even = (pmode == 1);
    p = (pmode == 1) ? ^m : ~^m;
    if (badpar) p = ~p;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) drive_bit(m[i], glitch);
    if (pmode != 0) drive_bit(p, 1'b0);
    drive_bit(~badstop, 1'b0);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic clear_ready();
    drf_clr_n = 1'b0;
    @(negedge clk);
    drf_clr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; len_sel = 2'b11; par_off = 1'b1;
    par_even = 1'b1; drf_clr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", {31'd0, rx_ready}, 0);
    chk("R1 flags in reset", {29'd0, err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 word after reset", {24'd0, rx_word}, 0);
    chk("R1 ready after reset", {31'd0, rx_ready}, 0);

    // R3 R7 R8: full sweep of every value at every length
    for (int nb = 5; nb <= 8; nb++) begin
      for (int d = 0; d < (1 << nb); d++) begin
        clear_ready();
        send(8'(d), nb, d % 3, 1'b0, 1'b0, 1'b0);
        chk($sformatf("R3 word len%0d", nb), {24'd0, rx_word}, d);
        chk("R5 ready after load", {31'd0, rx_ready}, 1);
        chk("R7 no parity error", {31'd0, err_parity}, 0);
        chk("R6 no frame error", {31'd0, err_frame}, 0);
      end
    end

    // R5: clear drops ready, word unchanged
    clear_ready();
    chk("R5 ready cleared", {31'd0, rx_ready}, 0);
    chk("R5 word kept", {24'd0, rx_word}, 255);

    // R2: short low pulse is rejected
    rxd = 1'b0; repeat (5) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    chk("R2 noise pulse ignored", {31'd0, rx_ready}, 0);
    chk("R2 word after noise", {24'd0, rx_word}, 255);

    // R4: edges of each data bit corrupted
    send(8'hA5, 8, 0, 1'b0, 1'b0, 1'b1);
    chk("R4 glitched word", {24'd0, rx_word}, 32'hA5);
    clear_ready();
    send(8'h16, 5, 1, 1'b0, 1'b0, 1'b1);
    chk("R4 glitched short word", {24'd0, rx_word}, 32'h16);
    clear_ready();

    // R7: wrong parity bit, both senses
    send(8'h3C, 8, 1, 1'b1, 1'b0, 1'b0);
    chk("R7 even mismatch", {31'd0, err_parity}, 1);
    clear_ready();
    send(8'h07, 6, 2, 1'b1, 1'b0, 1'b0);
    chk("R7 odd mismatch", {31'd0, err_parity}, 1);
    // R8: inhibit forces parity error low
    par_off = 1'b1;
    @(negedge clk);
    chk("R8 inhibit holds low", {31'd0, err_parity}, 0);
    clear_ready();

    // R6 R10: framing error, then a clean word clears it
    send(8'h55, 7, 0, 1'b0, 1'b1, 1'b0);
    chk("R6 frame error set", {31'd0, err_frame}, 1);
    chk("R6 word with bad stop", {24'd0, rx_word}, 32'h55);
    repeat (20) @(negedge clk);
    chk("R10 flags held between loads", {31'd0, err_frame}, 1);
    clear_ready();
    send(8'h2A, 7, 2, 1'b0, 1'b0, 1'b0);
    chk("R10 frame error cleared", {31'd0, err_frame}, 0);
    chk("R10 parity clean", {31'd0, err_parity}, 0);

    // R9: overrun with no clear, then cleared by a load after clear
    send(8'h81, 8, 1, 1'b0, 1'b0, 1'b0);
    chk("R9 overrun set", {31'd0, err_overrun}, 1);
    chk("R9 newest word kept", {24'd0, rx_word}, 32'h81);
    chk("R9 ready still set", {31'd0, rx_ready}, 1);
    clear_ready();
    chk("R9 overrun survives clear", {31'd0, err_overrun}, 1);
    send(8'h42, 8, 0, 1'b0, 1'b0, 1'b0);
    chk("R9 overrun cleared", {31'd0, err_overrun}, 0);

    // R1: master reset with flags set
    send(8'h13, 5, 0, 1'b0, 1'b1, 1'b0);
    chk("R1 pre-reset overrun", {31'd0, err_overrun}, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset clears flags",
        {28'd0, rx_ready, err_parity, err_frame, err_overrun}, 0);
    chk("R1 reset clears word", {24'd0, rx_word}, 0);

    summary();
  end
endmodule